// File: doc/BRIEF.md
# Four-Port Register-File Calculator with Conditional Skip

The block serves four independent command ports that share one file of sixteen 32-bit data registers. A command names up to two source registers and one destination register. Arithmetic and shift commands take their operands from the register file, not from the port's data bus. A store command copies the port's data bus into a register. A fetch command returns a register's value to the port. Two compare commands, branch-if-zero and branch-if-equal, can arm a skip on their port. The next command issued on that port is then not executed and is answered with a distinct code.

Each port holds at most one command at a time. A command presented in one clock cycle is answered in the next. Its 2-bit tag is echoed back, and a tag value must not be active on two ports in the same cycle. The block enforces this rule. When several ports write the same register in one cycle, the writes are ordered by port number.

Top module: `calc_rf_top`

## Requirements
- R1: Reset clears all sixteen registers to zero and clears every skip flag. After reset every port reports response 2'b00, tag 0 and data 0.
- R2: Add (opcode 4'h1) writes srcA+srcB to dst and answers 2'b01 with the sum on data. A carry out of bit 31 answers 2'b10 with data 0, and nothing is written.
- R3: Subtract (opcode 4'h2) writes srcA-srcB to dst and answers 2'b01 with the difference. When srcB > srcA it answers 2'b10 with data 0, and nothing is written.
- R4: Shift-left (4'h3) and shift-right (4'h4) move srcA by the low 5 bits of srcB, filling with zeros. The result is written to dst and returned on data with response 2'b01.
- R5: Store (4'h9) writes the port data bus to dst and answers 2'b01 with data 0. Fetch (4'hA) returns the value of srcA with response 2'b01 and writes nothing.
- R6: Branch-if-zero (4'hC) arms the port's skip flag when srcA is zero. Branch-if-equal (4'hD) arms it when srcA equals srcB. Both answer 2'b01 with data 0. The next non-idle command on that port is answered 2'b11 with data 0, writes nothing and clears the flag. Idle cycles leave the flag armed.
- R7: A branch issued while the skip flag is armed is itself skipped. It answers 2'b11, is not evaluated, and clears the flag.
- R8: When two ports issue commands with the same tag in one cycle, the higher-numbered port's command is rejected. It answers 2'b10 with data 0 and has no effect on registers or on its skip flag.
- R9: When several ports write the same register in one cycle, the register takes the value from the highest-numbered writing port.
- R10: Any other nonzero opcode answers 2'b10 with data 0 and has no effect. Opcode 4'h0 is idle and answers 2'b00 with tag 0 and data 0.
- R11: The response for a command appears on the edge after the command is sampled and carries the command's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4x4 | Opcode per port |
| tag_i | input | 4x2 | Command tag per port |
| src_a_i | input | 4x4 | First source register index per port |
| src_b_i | input | 4x4 | Second source register index per port |
| dst_i | input | 4x4 | Destination register index per port |
| data_i | input | 4x32 | Store data per port |
| resp_o | output | 4x2 | Response code per port |
| rtag_o | output | 4x2 | Echoed tag per port |
| data_o | output | 4x32 | Result or fetched data per port |

## Verification
Operand pairs at the carry and borrow edges are used to separate a true overflow from a result that only just fits. These include all-ones plus one, all-ones minus one plus one, equal subtraction, and a subtrahend one larger than the minuend. Shift amounts of 0 and 31 test the range of the amount field. Branch sequences cover a taken branch followed by idle cycles, a branch directly after a taken branch, and a branch that is not taken. Together they show whether the skip is consumed by the right command. Same-tag and same-destination collisions across ports, followed by a long random mix on all four ports, show whether port ordering and tag rejection hold under concurrent traffic.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int OPW  = 4;
  localparam int TAGW = 2;

  localparam logic [OPW-1:0] OP_NOP   = 4'h0;
  localparam logic [OPW-1:0] OP_ADD   = 4'h1;
  localparam logic [OPW-1:0] OP_SUB   = 4'h2;
  localparam logic [OPW-1:0] OP_SHL   = 4'h3;
  localparam logic [OPW-1:0] OP_SHR   = 4'h4;
  localparam logic [OPW-1:0] OP_STORE = 4'h9;
  localparam logic [OPW-1:0] OP_FETCH = 4'hA;
  localparam logic [OPW-1:0] OP_BZ    = 4'hC;
  localparam logic [OPW-1:0] OP_BEQ   = 4'hD;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_ERR  = 2'b10,
    RSP_SKIP = 2'b11
  } resp_e;
endpackage

// File: rtl/calc_tag_arb.sv
module calc_tag_arb
  import calc_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic [NP-1:0][OPW-1:0]  op_i,
  input  logic [NP-1:0][TAGW-1:0] tag_i,
  output logic [NP-1:0]           reject_o
);
  // a port loses to any lower-numbered active port holding the same tag
  always_comb begin
    reject_o = '0;
    for (int p = 1; p < NP; p++) begin
      for (int q = 0; q < p; q++) begin
        if (op_i[p] != OP_NOP && op_i[q] != OP_NOP && tag_i[p] == tag_i[q])
          reject_o[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/calc_regfile.sv
module calc_regfile #(
  parameter int NP   = 4,
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NP-1:0]            we_i,
  input  logic [NP-1:0][AW-1:0]    waddr_i,
  input  logic [NP-1:0][DW-1:0]    wdata_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  // ascending loop: highest port's write lands last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (we_i[p]) regs_q[waddr_i[p]] <= wdata_i[p];
      end
    end
  end

  assign regs_o = regs_q;

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(|we_i) |-> $stable(regs_q));
endmodule

// File: rtl/calc_port_exec.sv
module calc_port_exec
  import calc_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 4,
  localparam int SW = $clog2(DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OPW-1:0]  op_i,
  input  logic [TAGW-1:0] tag_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [DW-1:0]   data_i,
  input  logic [DW-1:0]   rd_a_i,
  input  logic [DW-1:0]   rd_b_i,
  input  logic            reject_i,
  output logic            we_o,
  output logic [AW-1:0]   waddr_o,
  output logic [DW-1:0]   wdata_o,
  output logic [1:0]      resp_o,
  output logic [TAGW-1:0] rtag_o,
  output logic [DW-1:0]   data_o
);
  logic            skip_q, skip_d;
  logic [1:0]      resp_d;
  logic [TAGW-1:0] tag_d;
  logic [DW-1:0]   data_d;
  logic [DW:0]     sum;
  logic [SW-1:0]   sh_amt;

  assign sum     = {1'b0, rd_a_i} + {1'b0, rd_b_i};
  assign sh_amt  = rd_b_i[SW-1:0];
  assign waddr_o = dst_i;

  always_comb begin
    we_o    = 1'b0;
    wdata_o = '0;
    resp_d  = RSP_NONE;
    data_d  = '0;
    tag_d   = '0;
    skip_d  = skip_q;
    if (op_i != OP_NOP) begin
      tag_d = tag_i;
      if (reject_i) begin
        resp_d = RSP_ERR;
      end else if (skip_q) begin
        resp_d = RSP_SKIP;
        skip_d = 1'b0;
      end else begin
        case (op_i)
          OP_ADD: begin
            if (sum[DW]) resp_d = RSP_ERR;
            else begin
              resp_d = RSP_OK; we_o = 1'b1;
              wdata_o = sum[DW-1:0]; data_d = sum[DW-1:0];
            end
          end
          OP_SUB: begin
            if (rd_b_i > rd_a_i) resp_d = RSP_ERR;
            else begin
              resp_d = RSP_OK; we_o = 1'b1;
              wdata_o = rd_a_i - rd_b_i; data_d = rd_a_i - rd_b_i;
            end
          end
          OP_SHL: begin
            resp_d = RSP_OK; we_o = 1'b1;
            wdata_o = rd_a_i << sh_amt; data_d = rd_a_i << sh_amt;
          end
          OP_SHR: begin
            resp_d = RSP_OK; we_o = 1'b1;
            wdata_o = rd_a_i >> sh_amt; data_d = rd_a_i >> sh_amt;
          end
          OP_STORE: begin
            resp_d = RSP_OK; we_o = 1'b1; wdata_o = data_i;
          end
          OP_FETCH: begin
            resp_d = RSP_OK; data_d = rd_a_i;
          end
          OP_BZ: begin
            resp_d = RSP_OK; skip_d = (rd_a_i == '0);
          end
          OP_BEQ: begin
            resp_d = RSP_OK; skip_d = (rd_a_i == rd_b_i);
          end
          default: resp_d = RSP_ERR;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q <= 1'b0;
      resp_o <= RSP_NONE;
      rtag_o <= '0;
      data_o <= '0;
    end else begin
      skip_q <= skip_d;
      resp_o <= resp_d;
      rtag_o <= tag_d;
      data_o <= data_d;
    end
  end

  // R6
  skip_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o == RSP_SKIP) |-> $past(skip_q));

  // R7
  skip_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o == RSP_SKIP) |-> !skip_q);

  // R11
  tag_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o != RSP_NONE) |-> (rtag_o == $past(tag_i)));

  // R8
  reject_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> (resp_o == RSP_ERR && $stable(skip_q)));
endmodule

// File: rtl/calc_rf_top.sv
module calc_rf_top
  import calc_pkg::*;
#(
  parameter int NP   = 4,
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NP-1:0][OPW-1:0]   op_i,
  input  logic [NP-1:0][TAGW-1:0]  tag_i,
  input  logic [NP-1:0][AW-1:0]    src_a_i,
  input  logic [NP-1:0][AW-1:0]    src_b_i,
  input  logic [NP-1:0][AW-1:0]    dst_i,
  input  logic [NP-1:0][DW-1:0]    data_i,
  output logic [NP-1:0][1:0]       resp_o,
  output logic [NP-1:0][TAGW-1:0]  rtag_o,
  output logic [NP-1:0][DW-1:0]    data_o
);
  logic [NP-1:0]           reject;
  logic [NP-1:0]           we;
  logic [NP-1:0][AW-1:0]   waddr;
  logic [NP-1:0][DW-1:0]   wdata;
  logic [NREG-1:0][DW-1:0] regs;

  calc_tag_arb #(.NP(NP)) i_arb (
    .op_i     (op_i),
    .tag_i    (tag_i),
    .reject_o (reject)
  );

  calc_regfile #(.NP(NP), .NREG(NREG), .DW(DW)) i_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .regs_o  (regs)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    calc_port_exec #(.DW(DW), .AW(AW)) i_exec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .op_i     (op_i[p]),
      .tag_i    (tag_i[p]),
      .dst_i    (dst_i[p]),
      .data_i   (data_i[p]),
      .rd_a_i   (regs[src_a_i[p]]),
      .rd_b_i   (regs[src_b_i[p]]),
      .reject_i (reject[p]),
      .we_o     (we[p]),
      .waddr_o  (waddr[p]),
      .wdata_o  (wdata[p]),
      .resp_o   (resp_o[p]),
      .rtag_o   (rtag_o[p]),
      .data_o   (data_o[p])
    );

    for (genvar q = 0; q < p; q++) begin : g_pair
      // R8
      tag_uniq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i[p] != OP_NOP && op_i[q] != OP_NOP && !reject[p] && !reject[q])
        |-> (tag_i[p] != tag_i[q]));
    end
  end
endmodule

// File: tb/test_calc_rf_top.sv
`timescale 1ns/1ps
module test_calc_rf_top;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0][3:0]  op, op_s;
  logic [NP-1:0][1:0]  tag, tag_s;
  logic [NP-1:0][3:0]  sa, sa_s, sb, sb_s, dst, dst_s;
  logic [NP-1:0][31:0] din, din_s;
  logic [NP-1:0][1:0]  resp, rtag;
  logic [NP-1:0][31:0] dout;

  calc_rf_top i_calc_rf_top (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .tag_i(tag), .src_a_i(sa),
    .src_b_i(sb), .dst_i(dst), .data_i(din), .resp_o(resp), .rtag_o(rtag),
    .data_o(dout)
  );

  int total = 0, bad = 0;
  bit [31:0] mregs[16];
  bit        mskip[NP];
  bit [1:0]  e_resp[NP], e_tag[NP];
  bit [31:0] e_data[NP];
  string     e_req = "R1";

  task automatic idle_s();
    for (int p = 0; p < NP; p++) begin
      op_s[p] = 0; tag_s[p] = 2'(p); sa_s[p] = 0; sb_s[p] = 0;
      dst_s[p] = 0; din_s[p] = 0;
    end
  endtask

  task automatic compare();
    for (int p = 0; p < NP; p++) begin
      total++;
      if (resp[p] !== e_resp[p] || rtag[p] !== e_tag[p] || dout[p] !== e_data[p]) begin
        bad++;
        $display("FAIL %s port%0d act resp=%b tag=%0d data=%h exp resp=%b tag=%0d data=%h",
                 e_req, p, resp[p], rtag[p], dout[p], e_resp[p], e_tag[p], e_data[p]);
      end
    end
  endtask

  // behavioural reference for one command cycle
  task automatic model();
    bit [31:0] snap[16];
    bit        rej;
    longint    a, b, r;
    snap = mregs;
    for (int p = 0; p < NP; p++) begin
      e_resp[p] = 0; e_tag[p] = 0; e_data[p] = 0;
      if (op_s[p] == 0) continue;
      e_tag[p] = tag_s[p];
      rej = 0;
      for (int q = 0; q < p; q++)
        if (op_s[q] != 0 && tag_s[q] == tag_s[p]) rej = 1;
      a = snap[sa_s[p]]; b = snap[sb_s[p]];
      if (rej) begin e_resp[p] = 2'b10; continue; end
      if (mskip[p]) begin e_resp[p] = 2'b11; mskip[p] = 0; continue; end
      e_resp[p] = 2'b01;
      case (op_s[p])
        4'h1: begin r = a + b;
          if (r > 64'hFFFF_FFFF) e_resp[p] = 2'b10;
          else begin mregs[dst_s[p]] = 32'(r); e_data[p] = 32'(r); end end
        4'h2: begin
          if (b > a) e_resp[p] = 2'b10;
          else begin mregs[dst_s[p]] = 32'(a - b); e_data[p] = 32'(a - b); end end
        4'h3: begin r = (a << (b % 32)) & 64'hFFFF_FFFF;
          mregs[dst_s[p]] = 32'(r); e_data[p] = 32'(r); end
        4'h4: begin r = a >> (b % 32);
          mregs[dst_s[p]] = 32'(r); e_data[p] = 32'(r); end
        4'h9: mregs[dst_s[p]] = din_s[p];
        4'hA: e_data[p] = 32'(a);
        4'hC: mskip[p] = (a == 0);
        4'hD: mskip[p] = (a == b);
        default: e_resp[p] = 2'b10;
      endcase
    end
  endtask

  task automatic cyc(input string req);
    @(negedge clk);
    compare();
    op = op_s; tag = tag_s; sa = sa_s; sb = sb_s; dst = dst_s; din = din_s;
    model();
    e_req = req;
  endtask

  task automatic set(input int p, input bit [3:0] o, input bit [3:0] a,
                     input bit [3:0] b, input bit [3:0] d, input bit [31:0] v);
    op_s[p] = o; sa_s[p] = a; sb_s[p] = b; dst_s[p] = d; din_s[p] = v;
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_s();
    op = '0; tag = '0; sa = '0; sb = '0; dst = '0; din = '0;
    for (int i = 0; i < 16; i++) mregs[i] = 0;
    for (int p = 0; p < NP; p++) begin mskip[p] = 0; e_resp[p] = 0; e_tag[p] = 0; e_data[p] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state, then every register reads zero
    cyc("R1");
    for (int k = 0; k < 4; k++) begin
      idle_s();
      for (int p = 0; p < NP; p++) set(p, 4'hA, 4'(4*k+p), 0, 0, 0);
      cyc("R1");
    end

    // R5: store and fetch
    idle_s();
    set(0, 4'h9, 0, 0, 3, 32'd100); set(1, 4'h9, 0, 0, 4, 32'd50);
    set(2, 4'h9, 0, 0, 6, 32'hFFFF_FFFF); set(3, 4'h9, 0, 0, 7, 32'd1);
    cyc("R5");
    idle_s(); set(0, 4'hA, 3, 0, 0, 0); set(3, 4'hA, 6, 0, 0, 0); cyc("R5");
    idle_s(); set(1, 4'h9, 0, 0, 9, 32'hFFFF_FFFE); set(2, 4'h9, 0, 0, 2, 32'd2); cyc("R5");

    // R2: add, carry by one, sum exactly all ones
    idle_s(); set(0, 4'h1, 3, 4, 5, 0); set(1, 4'h1, 6, 7, 8, 0);
    set(2, 4'h1, 9, 7, 10, 0); cyc("R2");
    idle_s(); set(0, 4'hA, 8, 0, 0, 0); set(1, 4'hA, 10, 0, 0, 0); cyc("R2");

    // R3: equal operands, subtrahend one above minuend
    idle_s(); set(0, 4'h2, 3, 3, 11, 0); set(1, 4'h2, 7, 2, 12, 0);
    set(3, 4'h2, 3, 4, 13, 0); cyc("R3");
    idle_s(); set(0, 4'hA, 12, 0, 0, 0); cyc("R3");

    // R4: shift by 0 and by 31 (r14 = 31)
    idle_s(); set(0, 4'h9, 0, 0, 14, 32'd31); cyc("R4");
    idle_s(); set(0, 4'h3, 6, 0, 11, 0); set(1, 4'h3, 6, 14, 12, 0);
    set(2, 4'h4, 6, 14, 13, 0); set(3, 4'h4, 3, 2, 15, 0); cyc("R4");

    // R6: taken branch, idle gap, skipped store, then normal store
    idle_s(); set(0, 4'hC, 0, 0, 0, 0); set(1, 4'hD, 3, 4, 0, 0);
    set(2, 4'hD, 3, 3, 0, 0); cyc("R6");
    idle_s(); cyc("R6");
    idle_s(); set(0, 4'h9, 0, 0, 1, 32'hDEAD); set(1, 4'h9, 0, 0, 1, 32'hBEEF);
    set(2, 4'h1, 3, 4, 1, 0); cyc("R6");
    idle_s(); set(0, 4'hA, 1, 0, 0, 0); set(2, 4'h9, 0, 0, 1, 32'h55); cyc("R6");
    idle_s(); set(0, 4'hA, 1, 0, 0, 0); cyc("R6");

    // R7: branch right after a taken branch is skipped, flag then clear
    idle_s(); set(3, 4'hC, 0, 0, 0, 0); cyc("R7");
    idle_s(); set(3, 4'hC, 0, 0, 0, 0); cyc("R7");
    idle_s(); set(3, 4'h9, 0, 0, 15, 32'h77); cyc("R7");
    idle_s(); set(3, 4'hA, 15, 0, 0, 0); cyc("R7");

    // R8: same tag on ports 0 and 2; port 2 rejected, its skip not touched
    idle_s(); tag_s[2] = 2'd0;
    set(0, 4'h9, 0, 0, 4, 32'h11); set(2, 4'h9, 0, 0, 5, 32'h22); cyc("R8");
    idle_s(); tag_s[3] = 2'd1; set(1, 4'hC, 0, 0, 0, 0); set(3, 4'hC, 0, 0, 0, 0); cyc("R8");
    idle_s(); set(0, 4'hA, 5, 0, 0, 0); set(3, 4'h9, 0, 0, 6, 32'h33); cyc("R8");
    idle_s(); set(0, 4'hA, 6, 0, 0, 0); set(1, 4'hA, 6, 0, 0, 0); cyc("R8");

    // R9: all ports store to one register
    idle_s();
    for (int p = 0; p < NP; p++) set(p, 4'h9, 0, 0, 2, 32'(32'hA0 + p));
    cyc("R9");
    idle_s(); set(1, 4'hA, 2, 0, 0, 0); cyc("R9");

    // R10: undefined opcodes
    idle_s(); set(0, 4'hF, 0, 0, 2, 0); set(1, 4'h5, 2, 2, 2, 0);
    set(2, 4'hB, 0, 0, 2, 0); cyc("R10");
    idle_s(); set(0, 4'hA, 2, 0, 0, 0); cyc("R10");

    // R11: random traffic on all ports
    for (int n = 0; n < 600; n++) begin
      for (int p = 0; p < NP; p++) begin
        int unsigned o;
        o = $urandom_range(0, 15);
        op_s[p] = (o > 10) ? 4'($urandom_range(0, 15)) :
                  (o < 2) ? 4'h0 : 4'({4'h1, 4'h2, 4'h3, 4'h4, 4'h9, 4'hA, 4'hC, 4'hD, 4'h9}[o - 2]);
        tag_s[p] = 2'($urandom_range(0, 3));
        sa_s[p] = 4'($urandom_range(0, 15)); sb_s[p] = 4'($urandom_range(0, 15));
        dst_s[p] = 4'($urandom_range(0, 15));
        case ($urandom_range(0, 3))
          0: din_s[p] = 32'hFFFF_FFFF - 32'($urandom_range(0, 3));
          1: din_s[p] = 32'($urandom_range(0, 40));
          default: din_s[p] = $urandom;
        endcase
      end
      cyc("R11");
    end
    idle_s(); cyc("R11");
    @(negedge clk);
    compare();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule